// File: doc/BRIEF.md
# Charge-Sampling Voltage Sensor Sequencer

This block runs the digital side of a sensing round for a voltage sensor that measures a varying supply without any reference. The sensor first lets a small sampling capacitor charge from the supply. It then connects that capacitor to a self-timed pulse counter, and the charge drives the counter until it runs out. The amount of work the counter completes is the measurement. The sequencer drives the switch enables and the discharge strobe for this round. It also counts the pulses that come back, but only while the capacitor is connected.

A round starts on a request. It passes through these steps in order:

1. A charge phase of programmable length.
2. One idle cycle with both switches open.
3. A conversion phase of programmable length.
4. One latch cycle, in which the bypass switch is closed and counting stops.
5. One discharge cycle, which readies the capacitor for the next round.

In the discharge cycle the latched count appears on the output together with a one-cycle completion flag. The internal pulse count saturates at its maximum value and does not wrap. A request that arrives while a round is in flight is ignored.

Top module: `csvs_sensor_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every switch enable and the discharge strobe are low, `count_o` is 0 and `done_o` is 0.
- R2: When `start_i` is high at a clock edge while no round is running, `charge_sw_o` goes high from the next cycle. It stays high for `charge_len_i` cycles, or for one cycle when that value is 0. `connect_sw_o` is low throughout.
- R3: Exactly one cycle with both `charge_sw_o` and `connect_sw_o` low follows the charge phase. The two enables are never high in the same cycle.
- R4: After that idle cycle, `connect_sw_o` is high for `conv_len_i` cycles, or for one cycle when that value is 0.
- R5: Directly after the conversion phase, `bypass_sw_o` is high for exactly one cycle. In that cycle the other switch enables and the discharge strobe are low. At most one of the four outputs `charge_sw_o`, `connect_sw_o`, `bypass_sw_o` and `discharge_o` is high in any cycle.
- R6: The cycle after the bypass cycle is a discharge cycle. In it:
  - `discharge_o` is high;
  - `done_o` pulses high for that single cycle;
  - `count_o` holds the new count.

  `count_o` changes only in a cycle where `done_o` is high. The block is then idle again.
- R7: `pulse_i` is sampled on every clock edge. Suppose it reads 0 at edge t and 1 at edge t+1. That rising edge adds one to the count if `connect_sw_o` is high in the cycle that follows edge t+2.
- R8: The count stops at 2^COUNT_W-1 and does not wrap, however many rising edges arrive during conversion.
- R9: A `start_i` that arrives while a round is running has no effect on the switch sequence or on the result.
- R10: The charge and conversion lengths are captured when a round starts. Changes to `charge_len_i` and `conv_len_i` during the round do not alter that round.
- R11: The count is cleared when a round starts, so each result counts only the pulses of its own round.
- R12: Rising edges on `pulse_i` that fall outside the window of R7 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a sensing round |
| charge_len_i | input | TIME_W | Charge phase length in cycles (0 acts as 1) |
| conv_len_i | input | TIME_W | Conversion phase length in cycles (0 acts as 1) |
| pulse_i | input | 1 | Asynchronous pulse train from the self-timed counter |
| charge_sw_o | output | 1 | Closes the switch between supply and sampling capacitor |
| connect_sw_o | output | 1 | Closes the switch between capacitor and counter |
| bypass_sw_o | output | 1 | Closes the bypass switch that ends conversion |
| discharge_o | output | 1 | Strobe that empties the sampling capacitor |
| count_o | output | COUNT_W | Count latched at the end of the last round |
| done_o | output | 1 | One-cycle flag marking a new `count_o` |

## Verification
The properties take for granted that `pulse_i` holds each level for at least two clock cycles. If it does not, the synchronizer can miss an edge. The stimulus keeps to this by building pulse trains only from half-periods of two or more cycles, or by holding the pin low. The properties put no limit on `start_i`, so the bench asserts requests in the middle of conversion. The bench also changes the length inputs during a round to check that the captured values stay in force.

// File: rtl/csvs_pkg.sv
package csvs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CHARGE  = 3'd1,
        PH_GAP     = 3'd2,
        PH_CONVERT = 3'd3,
        PH_LATCH   = 3'd4,
        PH_DRAIN   = 3'd5
    } phase_e;

endpackage

// File: rtl/csvs_pulse_sync.sv
module csvs_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], pulse_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // edge seen between the last synchronized stage and its delayed copy
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/csvs_sat_counter.sv
module csvs_sat_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                     cnt_d = '0;
        else if (inc_i && cnt_q != TOP) cnt_d = cnt_q + WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/csvs_phase_ctrl.sv
module csvs_phase_ctrl
    import csvs_pkg::*;
#(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TIME_W-1:0] charge_len_i,
    input  logic [TIME_W-1:0] conv_len_i,
    output phase_e            phase_o,
    output logic              accept_o
);
    typedef struct packed {
        phase_e              phase;
        logic [TIME_W-1:0]   timer;
        logic [TIME_W-1:0]   chg_last;
        logic [TIME_W-1:0]   conv_last;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    function automatic logic [TIME_W-1:0] last_of(input logic [TIME_W-1:0] len);
        return (len == '0) ? '0 : len - TIME_W'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    accept         = 1'b1;
                    st_d.phase     = PH_CHARGE;
                    st_d.timer     = '0;
                    st_d.chg_last  = last_of(charge_len_i);
                    st_d.conv_last = last_of(conv_len_i);
                end
            end
            PH_CHARGE: begin
                if (st_q.timer == st_q.chg_last) begin
                    st_d.phase = PH_GAP;
                    st_d.timer = '0;
                end else begin
                    st_d.timer = st_q.timer + TIME_W'(1);
                end
            end
            PH_GAP: st_d.phase = PH_CONVERT;
            PH_CONVERT: begin
                if (st_q.timer == st_q.conv_last) begin
                    st_d.phase = PH_LATCH;
                    st_d.timer = '0;
                end else begin
                    st_d.timer = st_q.timer + TIME_W'(1);
                end
            end
            PH_LATCH: st_d.phase = PH_DRAIN;
            PH_DRAIN: st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.timer     <= '0;
            st_q.chg_last  <= '0;
            st_q.conv_last <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign accept_o = accept;

endmodule

// File: rtl/csvs_sensor_seq.sv
module csvs_sensor_seq
    import csvs_pkg::*;
#(
    parameter int TIME_W    = 12,
    parameter int COUNT_W   = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TIME_W-1:0]  charge_len_i,
    input  logic [TIME_W-1:0]  conv_len_i,
    input  logic               pulse_i,
    output logic               charge_sw_o,
    output logic               connect_sw_o,
    output logic               bypass_sw_o,
    output logic               discharge_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               done_o
);
    typedef struct packed {
        logic [COUNT_W-1:0] result;
        logic               done;
    } out_t;

    phase_e             phase;
    logic               accept;
    logic               rise;
    logic [COUNT_W-1:0] tally;
    out_t               out_d, out_q;

    csvs_phase_ctrl #(.TIME_W(TIME_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .charge_len_i (charge_len_i),
        .conv_len_i   (conv_len_i),
        .phase_o      (phase),
        .accept_o     (accept)
    );

    csvs_pulse_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_i),
        .rise_o  (rise)
    );

    csvs_sat_counter #(.WIDTH(COUNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .inc_i (rise && (phase == PH_CONVERT)),
        .cnt_o (tally)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = (phase == PH_LATCH);
        if (phase == PH_LATCH) out_d.result = tally;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign charge_sw_o  = (phase == PH_CHARGE);
    assign connect_sw_o = (phase == PH_CONVERT);
    assign bypass_sw_o  = (phase == PH_LATCH);
    assign discharge_o  = (phase == PH_DRAIN);
    assign count_o      = out_q.result;
    assign done_o       = out_q.done;

endmodule

// File: rtl/csvs_sensor_seq_chk.sv
module csvs_sensor_seq_chk #(
    parameter int COUNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               charge_sw_o,
    input logic               connect_sw_o,
    input logic               bypass_sw_o,
    input logic               discharge_o,
    input logic [COUNT_W-1:0] count_o,
    input logic               done_o
);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(charge_sw_o && connect_sw_o));

    p_break_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(charge_sw_o) |-> !connect_sw_o);

    p_make_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(charge_sw_o) |=> connect_sw_o);

    p_bypass_follows_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_sw_o) |-> $past(connect_sw_o));

    p_single_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({charge_sw_o, connect_sw_o, bypass_sw_o, discharge_o}));

    p_drain_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_sw_o |=> (discharge_o && done_o && !bypass_sw_o));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(count_o));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (connect_sw_o && start_i) |=> !charge_sw_o);

endmodule

bind csvs_sensor_seq csvs_sensor_seq_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .charge_sw_o  (charge_sw_o),
    .connect_sw_o (connect_sw_o),
    .bypass_sw_o  (bypass_sw_o),
    .discharge_o  (discharge_o),
    .count_o      (count_o),
    .done_o       (done_o)
);

// File: tb/csvs_sensor_seq_bench.sv
`timescale 1ns/1ps
module csvs_sensor_seq_bench;
    localparam int TW  = 12;
    localparam int CW  = 8;
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [TW-1:0] charge_len_i = '0;
    logic [TW-1:0] conv_len_i = '0;
    logic          pulse_i = 1'b0;
    logic          charge_sw_o, connect_sw_o, bypass_sw_o, discharge_o, done_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int fails  = 0;
    int half   = 0;     // pulse half-period in cycles, 0 holds the pin low
    int cycles = 0;
    string scen = "";

    always #5 clk = ~clk;

    csvs_sensor_seq #(.TIME_W(TW), .COUNT_W(CW)) u_csvs_sensor_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .charge_len_i(charge_len_i), .conv_len_i(conv_len_i), .pulse_i(pulse_i),
        .charge_sw_o(charge_sw_o), .connect_sw_o(connect_sw_o),
        .bypass_sw_o(bypass_sw_o), .discharge_o(discharge_o),
        .count_o(count_o), .done_o(done_o)
    );

    // ---------------- behavioural reference ----------------
    int   m_step = 0;    // 0 idle,1 charge,2 gap,3 convert,4 bypass,5 drain
    int   m_left = 0;
    int   m_conv = 0;
    int   m_acc  = 0;
    int   m_out  = 0;
    bit   m_done = 0;
    bit   smp[$];        // pulse samples, newest at the back

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step = 0; m_left = 0; m_conv = 0; m_acc = 0; m_out = 0; m_done = 0;
            smp = {1'b0, 1'b0, 1'b0};
        end else begin
            bit edge_seen;
            edge_seen = smp[1] && !smp[0];   // samples from three and two edges ago
            m_done = (m_step == 4);
            case (m_step)
                0: if (start_i) begin
                       m_step = 1;
                       m_acc  = 0;
                       m_left = (charge_len_i == 0) ? 1 : int'(charge_len_i);
                       m_conv = (conv_len_i == 0) ? 1 : int'(conv_len_i);
                   end
                1: begin m_left--; if (m_left == 0) m_step = 2; end
                2: begin m_step = 3; m_left = m_conv; end
                3: begin
                       if (edge_seen && m_acc < TOP) m_acc++;
                       m_left--; if (m_left == 0) m_step = 4;
                   end
                4: begin m_out = m_acc; m_step = 5; end
                default: m_step = 0;
            endcase
            void'(smp.pop_front());
            smp.push_back(pulse_i);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({"R2/R9/R10 charge_sw ", scen}, charge_sw_o, m_step == 1);
            check({"R3/R4 connect_sw ", scen},    connect_sw_o, m_step == 3);
            check({"R5 bypass_sw ", scen},        bypass_sw_o, m_step == 4);
            check({"R6 discharge ", scen},        discharge_o, m_step == 5);
            check({"R6 done ", scen},             done_o, m_done);
            check({"R7/R11/R12 count ", scen},    count_o, m_out);
        end
    end

    // pulse train generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (half == 0) begin pulse_i = 1'b0; ph = 0; end
            else begin
                ph++;
                if (ph >= half) begin pulse_i = ~pulse_i; ph = 0; end
            end
        end
    end

    task automatic run_round(int chg, int conv, int hp, string tag);
        scen = tag;
        half = hp;
        @(negedge clk);
        charge_len_i = TW'(chg); conv_len_i = TW'(conv); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check("R1 reset switches", {charge_sw_o, connect_sw_o, bypass_sw_o, discharge_o}, 0);
        check("R1 reset count", count_o, 0);
        check("R1 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle count", count_o, 0);

        run_round(5, 40, 2, "R7 nominal");
        run_round(3, 30, 5, "R7 slow pulses");
        run_round(1, 1, 2, "R2 R4 one-cycle phases");
        run_round(0, 0, 3, "R2 R4 zero lengths");
        run_round(4, 25, 0, "R11 no pulses");
        check("R11 count cleared", count_o, 0);

        // R8: long conversion with fast pulses saturates
        run_round(2, 1200, 2, "R8 saturation");
        check("R8 saturated count", count_o, TOP);

        // R9 and R10: start pulses and length changes mid-round
        scen = "R9 R10 mid-round";
        half = 3;
        @(negedge clk);
        charge_len_i = TW'(6); conv_len_i = TW'(20); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        charge_len_i = TW'(50); conv_len_i = TW'(2);
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);

        // R12: pulses only during charge, stopped well before conversion
        scen = "R12 charge-only pulses";
        half = 2;
        @(negedge clk);
        charge_len_i = TW'(40); conv_len_i = TW'(30); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        half = 0;
        while (!done_o) @(negedge clk);
        check("R12 edges outside conversion", count_o, 0);
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule